// File: doc/BRIEF.md
# Addressable Latch with Demultiplex Mode

This block is a small register that takes data one bit at a time. A binary select input names one bit position of a parallel output word, and a single data bit is written into that position on a clock edge. The whole output word can be read on every cycle, whatever the select and control inputs are doing.

Two control inputs give four modes. The first is a write-block input and the second is a functional clear input. With both low, the data bit goes into the selected position and the other positions keep their values. With write-block high and clear low, the register holds. With both high, the whole word is cleared. With clear high and write-block low, the block acts as a one-of-N demultiplexer: the selected output takes the data bit and every other output goes to zero.

All inputs are sampled on the rising clock edge and the output word comes from a register. A result therefore shows on the output one cycle after the inputs that caused it. A separate synchronous system reset sets the word to zero, apart from the functional clear input.

Top module: `addr_latch_demux`

## Requirements
- R1: When `rst` is high at a rising edge, `q` is all zeros after that edge, whatever the other inputs are.
- R2: With `clr_req`=0 and `wr_block`=0 at an edge, bit `q[sel]` equals `din` after that edge. `sel` is read as an unsigned binary number with `sel[0]` the least significant bit, and its value is the bit index.
- R3: In that same write mode, every bit of `q` other than bit `sel` keeps the value it had before the edge.
- R4: With `clr_req`=0 and `wr_block`=1 at an edge, `q` does not change, whatever `sel` and `din` are.
- R5: With `clr_req`=1 and `wr_block`=1 at an edge, `q` is all zeros after that edge.
- R6: With `clr_req`=1 and `wr_block`=0 at an edge, `q[sel]` equals `din` after that edge and every other bit of `q` is 0.
- R7: After a demultiplexer cycle, a following write or hold cycle starts from exactly the word that the demultiplexer cycle left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous system reset, active high |
| wr_block | input | 1 | High blocks writes (hold, or clear together with `clr_req`) |
| clr_req | input | 1 | Functional clear; with `wr_block` low, selects demultiplexer mode |
| sel | input | ADDR_W | Binary index of the target bit |
| din | input | 1 | Data bit |
| q | output | 2**ADDR_W | Registered parallel output word |

## Verification
The bench goes after the way the two control inputs interact. A design that treated the clear input as a plain clear would zero the selected bit in demultiplexer mode, where it should take the data bit. A design that ignored write-block while clearing would keep old bits instead of wiping them. Hold cycles come with random select and data values, so a design that leaked a write during hold would show a changed bit. Select values at both ends of the range catch a decoder that is off by one. Demultiplexer cycles followed by write and hold cycles catch a design that restores old contents or leaves stale bits in place.

// File: rtl/alat_pkg.sv
package alat_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_WIPE  = 2'd2,
    MODE_DEMUX = 2'd3
  } alat_mode_e;
endpackage

// File: rtl/alat_mode_dec.sv
module alat_mode_dec
  import alat_pkg::*;
(
  input  logic       wr_block,
  input  logic       clr_req,
  output alat_mode_e mode
);
  always_comb begin
    unique case ({clr_req, wr_block})
      2'b00:   mode = MODE_WRITE;
      2'b01:   mode = MODE_HOLD;
      2'b11:   mode = MODE_WIPE;
      default: mode = MODE_DEMUX;
    endcase
  end
endmodule

// File: rtl/alat_sel_dec.sv
module alat_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [NBITS-1:0]  hit
);
  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    assign hit[i] = (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/alat_bit_cell.sv
module alat_bit_cell
  import alat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  alat_mode_e mode,
  input  logic       hit,
  input  logic       din,
  output logic       q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_WRITE: nxt = hit ? din : q;
      MODE_HOLD:  nxt = q;
      MODE_WIPE:  nxt = 1'b0;
      MODE_DEMUX: nxt = hit & din;
      default:    nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alat_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_block,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [NBITS-1:0]  q
);
  alat_mode_e       mode;
  logic [NBITS-1:0] hit;

  alat_mode_dec u_mode (
    .wr_block (wr_block),
    .clr_req  (clr_req),
    .mode     (mode)
  );

  alat_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
    .sel (sel),
    .hit (hit)
  );

  for (genvar b = 0; b < NBITS; b++) begin : g_cell
    alat_bit_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .hit  (hit[b]),
      .din  (din),
      .q    (q[b])
    );
  end
endmodule

// File: rtl/alat_checker.sv
module alat_checker #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_block,
  input logic              clr_req,
  input logic [ADDR_W-1:0] sel,
  input logic              din,
  input logic [NBITS-1:0]  q
);
  logic in_write, in_hold, in_wipe, in_demux;
  assign in_write = !clr_req && !wr_block;
  assign in_hold  = !clr_req &&  wr_block;
  assign in_wipe  =  clr_req &&  wr_block;
  assign in_demux =  clr_req && !wr_block;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (q == '0));

  assert_write_target_R2: assert property (@(posedge clk) disable iff (rst)
    in_write |=> (q[$past(sel)] == $past(din)));

  assert_write_others_R3: assert property (@(posedge clk) disable iff (rst)
    in_write |=> (((q ^ $past(q)) & ~(NBITS'(1) << $past(sel))) == '0));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    in_hold |=> $stable(q));

  assert_wipe_zero_R5: assert property (@(posedge clk) disable iff (rst)
    in_wipe |=> (q == '0));

  assert_demux_target_R6: assert property (@(posedge clk) disable iff (rst)
    in_demux |=> (q[$past(sel)] == $past(din)));

  assert_demux_single_R6: assert property (@(posedge clk) disable iff (rst)
    in_demux |=> ($countones(q) == int'($past(din))));
endmodule

bind addr_latch_demux alat_checker #(.ADDR_W(ADDR_W)) u_alat_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_block (wr_block),
  .clr_req  (clr_req),
  .sel      (sel),
  .din      (din),
  .q        (q)
);

// File: tb/addr_latch_demux_tb_top.sv
`timescale 1ns/1ps
module addr_latch_demux_tb_top;
  localparam int AW = 3;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_block;
  logic          clr_req;
  logic [AW-1:0] sel;
  logic          din;
  logic [NB-1:0] q;

  int total = 0;
  int bad   = 0;
  bit model [NB];

  always #4 clk = ~clk;

  addr_latch_demux #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_block(wr_block), .clr_req(clr_req),
    .sel(sel), .din(din), .q(q)
  );

  function automatic logic [NB-1:0] model_word();
    logic [NB-1:0] w;
    for (int i = 0; i < NB; i++) w[i] = model[i];
    return w;
  endfunction

  function automatic string mode_tag(logic c, logic w);
    if (!c && !w) return "R2 R3 write";
    if (!c &&  w) return "R4 hold";
    if ( c &&  w) return "R5 clear";
    return "R6 demux";
  endfunction

  task automatic check_q(string tag);
    total++;
    if (q !== model_word()) begin
      bad++;
      $display("FAIL %s: q=%b expected=%b", tag, q, model_word());
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge,
  // then compare at the next falling edge.
  task automatic step(logic r, logic c, logic w, int s, logic d, string tag_in);
    string tag;
    int    idx;
    rst = r; clr_req = c; wr_block = w; sel = AW'(s); din = d;
    idx = s;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NB; i++) model[i] = 1'b0;
    end else if (!c && !w) begin
      model[idx] = d;
    end else if (c && w) begin
      for (int i = 0; i < NB; i++) model[i] = 1'b0;
    end else if (c && !w) begin
      for (int i = 0; i < NB; i++) model[i] = (i == idx) ? d : 1'b0;
    end
    tag = (tag_in != "") ? tag_in : (r ? "R1 reset" : mode_tag(c, w));
    @(negedge clk);
    check_q(tag);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: run hung, got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; clr_req = 1'b0; wr_block = 1'b0; sel = '0; din = 1'b1;
    @(negedge clk);
    // R1: reset with a pending write still yields zeros
    step(1, 0, 0, 5, 1, "R1 reset");
    step(1, 1, 0, 2, 1, "R1 reset");

    // R2 R3: fill every position, both ends of the select range included
    for (int i = 0; i < NB; i++) step(0, 0, 0, i, 1, "R2 R3 fill");
    step(0, 0, 0, 0, 0, "R2 R3 low end");
    step(0, 0, 0, NB-1, 0, "R2 R3 high end");

    // R4: hold with varied select and data
    for (int i = 0; i < NB; i++) step(0, 0, 1, i, i[0], "R4 hold");

    // R5: clear a nonzero word
    step(0, 0, 0, 3, 1, "R2 write before clear");
    step(0, 1, 1, 3, 1, "R5 clear");

    // R6: demux over all positions and both data values
    for (int i = 0; i < NB; i++) begin
      step(0, 1, 0, i, 1, "R6 demux one");
      step(0, 1, 0, i, 0, "R6 demux zero");
    end

    // R7: leave demux, then write and hold on top of its result
    step(0, 1, 0, 6, 1, "R6 demux before exit");
    step(0, 0, 1, 2, 1, "R7 hold after demux");
    step(0, 0, 0, 1, 1, "R7 write after demux");
    step(0, 1, 0, NB-1, 1, "R6 demux top");
    step(0, 0, 0, 0, 1, "R7 write after demux top");

    // Random mix of all modes plus occasional reset
    for (int n = 0; n < 3000; n++) begin
      int rr;
      rr = $urandom_range(0, 63);
      step(rr == 0, 1'($urandom), 1'($urandom), $urandom_range(0, NB-1),
           1'($urandom), "");
    end

    step(1, 0, 1, 4, 1, "R1 reset late");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule